// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream, with a holding register placed in front of the shift chain. A rising edge on the capture strobe copies the parallel input bus into the holding register. A load request copies the held word into the shift chain. After that, each rising edge on the shift strobe moves the chain one stage toward the output and feeds a new serial bit into the first stage. An active-low clear empties the chain.

Because the holding register sits between the pins and the shift chain, the next word can be captured while the current word is still being shifted out. Both strobes are sampled on one system clock and treated as rising-edge enables. Clear and load are level requests that act on every clock edge while they are held active.

Top module: `piso_hold_shifter`

## Requirements
- R1: After reset, `ser_out` is 0, and the holding register and the shift chain hold all zeros. A load issued before any capture therefore shifts out only zeros.
- R2: On a clock edge where `cap_strobe` is sampled 1 and was sampled 0 on the previous edge, the holding register takes `par_in`. On any other edge it keeps its value, so a strobe held high captures only once.
- R3: On a clock edge where `clr_n` is 0, the shift chain becomes all zeros, whatever the other inputs are doing.
- R4: On a clock edge where `clr_n` is 1 and `load_n` is 0, the shift chain takes the held word. From the next cycle `ser_out` shows the held word's bit WIDTH-1.
- R5: On a rising edge of `shift_strobe`, with clear and load both inactive, stage 0 takes `ser_in` and each stage i>0 takes stage i-1. A strobe held high shifts only once.
- R6: When there is no clear, no load and no shift edge, the shift chain and `ser_out` keep their values.
- R7: Clear wins over load, and load wins over a shift edge in the same cycle.
- R8: When a capture edge and a load happen in the same cycle, the load transfers the word that was held before that cycle.
- R9: When a capture edge and a shift edge happen in the same cycle, both take effect.
- R10: Bit i of `par_in` maps to stage i. After a load, bit i reaches `ser_out` after WIDTH-1-i shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously |
| cap_strobe | input | 1 | Capture strobe; its rising edge latches `par_in` |
| shift_strobe | input | 1 | Shift strobe; its rising edge advances the chain |
| clr_n | input | 1 | Active-low synchronous clear of the shift chain |
| load_n | input | 1 | Active-low load of the held word into the shift chain |
| ser_in | input | 1 | Serial bit that enters stage 0 |
| par_in | input | WIDTH | Parallel word |
| ser_out | output | 1 | Last stage of the shift chain |

## Verification
The bench builds the block with the default WIDTH of 8. At this size a full load followed by eight shifts pushes every bit of a word out and then drains the serial fill within a few dozen cycles. This keeps capture, load and shift overlaps, and mid-stream reloads, cheap enough to repeat across thousands of random cycles. The directed part of the bench covers:
- priority collisions between clear, load and shift;
- capture and load in the same cycle;
- capture and shift in the same cycle;
- fills with all ones and with all zeros.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_KEEP  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_LOAD  = 2'd2,
    OP_SHIFT = 2'd3
  } sr_op_e;
endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/piso_rise_det.sv
module piso_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = level[i] & ~prev_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= level[i];
    end
  end
endmodule

// File: rtl/piso_word_hold.sv
module piso_word_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_q
);
  logic [WIDTH-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (cap_en) word_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/piso_shift_chain.sv
module piso_shift_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sr_op_e           op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] load_word,
  output logic [WIDTH-1:0] stage_q
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] stage_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign shifted[i] = ser_in;
    end else begin : g_body
      assign shifted[i] = stage_q[i-1];
    end
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: stage_d = '0;
      OP_LOAD:  stage_d = load_word;
      OP_SHIFT: stage_d = shifted;
      default:  stage_d = stage_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/piso_hold_shifter.sv
module piso_hold_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_strobe,
  input  logic             shift_strobe,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int NSTROBE = 2;
  localparam int LAST    = WIDTH - 1;

  logic               rst_sync_n;
  logic [NSTROBE-1:0] strobe_rise;
  logic               cap_rise;
  logic               sh_rise;
  logic [WIDTH-1:0]   hold_q;
  logic [WIDTH-1:0]   sr_q;
  sr_op_e             sr_op;

  piso_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  piso_rise_det #(.N(NSTROBE)) u_rise (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .level ({shift_strobe, cap_strobe}),
    .rise  (strobe_rise)
  );

  assign cap_rise = strobe_rise[0];
  assign sh_rise  = strobe_rise[1];

  piso_word_hold #(.WIDTH(WIDTH)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cap_en  (cap_rise),
    .word_in (par_in),
    .word_q  (hold_q)
  );

  always_comb begin
    if (!clr_n)       sr_op = OP_CLEAR;
    else if (!load_n) sr_op = OP_LOAD;
    else if (sh_rise) sr_op = OP_SHIFT;
    else              sr_op = OP_KEEP;
  end

  piso_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (sr_op),
    .ser_in    (ser_in),
    .load_word (hold_q),
    .stage_q   (sr_q)
  );

  assign ser_out = sr_q[LAST];
endmodule

// File: rtl/piso_hold_shifter_chk.sv
module piso_hold_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cap_strobe,
  input logic             shift_strobe,
  input logic             clr_n,
  input logic             load_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] hold_q,
  input logic [WIDTH-1:0] sr_q
);
  logic cap_prev;
  logic sh_prev;
  logic cap_edge;
  logic sh_edge;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_prev <= 1'b0;
      sh_prev  <= 1'b0;
    end else begin
      cap_prev <= cap_strobe;
      sh_prev  <= shift_strobe;
    end
  end

  assign cap_edge = cap_strobe & ~cap_prev;
  assign sh_edge  = shift_strobe & ~sh_prev;

  // R2
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_edge |=> hold_q == $past(par_in));

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_edge |=> $stable(hold_q));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_n |=> sr_q == '0);

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !load_n) |=> sr_q == $past(hold_q));

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && load_n && sh_edge) |=> sr_q == {$past(sr_q[WIDTH-2:0]), $past(ser_in)});

  // R6
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && load_n && !sh_edge) |=> $stable(sr_q));

  // R7
  load_beats_shift_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !load_n && sh_edge) |=> sr_q == $past(hold_q));
endmodule

bind piso_hold_shifter piso_hold_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cap_strobe   (cap_strobe),
  .shift_strobe (shift_strobe),
  .clr_n        (clr_n),
  .load_n       (load_n),
  .ser_in       (ser_in),
  .par_in       (par_in),
  .hold_q       (hold_q),
  .sr_q         (sr_q)
);

// File: tb/test_piso_hold_shifter.sv
`timescale 1ns/1ps
module test_piso_hold_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cap_strobe, shift_strobe, clr_n, load_n, ser_in;
  logic [W-1:0] par_in;
  logic         ser_out;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_hold, m_sr;
  logic         m_cap_prev, m_sh_prev;

  always #4 clk = ~clk;

  piso_hold_shifter #(.WIDTH(W)) i_piso_hold_shifter (
    .clk(clk), .rst_n(rst_n), .cap_strobe(cap_strobe), .shift_strobe(shift_strobe),
    .clr_n(clr_n), .load_n(load_n), .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
  );

  function automatic logic [W-1:0] next_sr(logic [W-1:0] sr, logic [W-1:0] hold,
                                           logic clr, logic ld, logic sh_edge, logic si);
    if (!clr)         return '0;
    else if (!ld)     return hold;
    else if (sh_edge) return {sr[W-2:0], si};
    return sr;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ser_out actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(logic cap, logic sh, logic clr, logic ld, logic si,
                      logic [W-1:0] pi, string tag);
    logic ce, se;
    string t;
    cap_strobe = cap; shift_strobe = sh; clr_n = clr; load_n = ld;
    ser_in = si; par_in = pi;
    @(posedge clk);
    ce = cap & ~m_cap_prev;
    se = sh & ~m_sh_prev;
    m_sr = next_sr(m_sr, m_hold, clr, ld, se, si);
    if (ce) m_hold = pi;
    m_cap_prev = cap;
    m_sh_prev = sh;
    @(negedge clk);
    if (tag != "") t = tag;
    else if (!clr) t = "R3";
    else if (!ld) t = "R4";
    else if (se) t = "R5";
    else t = "R6";
    check(t, ser_out, m_sr[W-1]);
  endtask

  task automatic shift_out(logic si, string tag);
    for (int k = 0; k < W; k++) begin
      step(0, 1, 1, 1, si, '0, tag);
      step(0, 0, 1, 1, si, '0, tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    rst_n = 0; cap_strobe = 0; shift_strobe = 0; clr_n = 1; load_n = 1;
    ser_in = 0; par_in = '0;
    m_hold = '0; m_sr = '0; m_cap_prev = 0; m_sh_prev = 0;
    repeat (3) @(negedge clk);
    check("R1", ser_out, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", ser_out, 1'b0);

    // R1: a load with nothing captured yields zeros
    step(0, 0, 1, 0, 0, 8'hFF, "R1");
    shift_out(1'b0, "R1");

    // R10: capture, load, shift out with a fill of ones
    step(1, 0, 1, 1, 0, 8'hA5, "R2");
    step(0, 0, 1, 1, 0, 8'h00, "R2");
    step(0, 0, 1, 0, 0, 8'h00, "R10");
    check("R10", ser_out, 1'b1);
    shift_out(1'b1, "R10");
    check("R5", ser_out, 1'b1);

    // R2: strobe held high captures once
    step(1, 0, 1, 1, 0, 8'h3C, "R2");
    step(1, 0, 1, 1, 0, 8'hC3, "R2");
    step(0, 0, 1, 0, 0, 8'h00, "R2");
    check("R2", ser_out, 1'b0);
    shift_out(1'b0, "R2");

    // R8: capture and load together transfer the older word
    step(1, 0, 1, 1, 0, 8'h80, "R8");
    step(0, 0, 1, 1, 0, 8'h00, "R8");
    step(1, 0, 1, 0, 0, 8'h01, "R8");
    check("R8", ser_out, 1'b1);

    // R7: clear beats load and shift; load beats shift
    step(0, 1, 0, 0, 1, 8'h00, "R7");
    check("R7", ser_out, 1'b0);
    step(0, 0, 1, 1, 0, 8'h00, "R7");
    step(0, 1, 1, 0, 0, 8'h00, "R7");
    check("R7", ser_out, 1'b0);

    // R9: capture and shift together both act
    step(0, 0, 1, 1, 0, 8'h00, "R9");
    step(1, 1, 1, 1, 1, 8'hFF, "R9");
    step(0, 0, 1, 0, 0, 8'h00, "R9");
    check("R9", ser_out, 1'b1);

    // R5: strobe held high shifts once; R6 idle holds
    step(1, 0, 1, 1, 0, 8'h40, "R5");
    step(0, 0, 1, 0, 0, 8'h00, "R5");
    step(0, 1, 1, 1, 0, 8'h00, "R5");
    check("R5", ser_out, 1'b1);
    step(0, 1, 1, 1, 0, 8'h00, "R5");
    check("R5", ser_out, 1'b1);
    step(0, 0, 1, 1, 0, 8'h00, "R6");
    check("R6", ser_out, 1'b1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(1, 0), $urandom_range(1, 0),
           ($urandom_range(19, 0) != 0), ($urandom_range(9, 0) != 0),
           $urandom_range(1, 0), W'($urandom), "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule